// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer

This block holds two down-counting timer/counters that share one prescaler and two external input pins. A two-bit mode field hands the same hardware to one of four jobs: a free-running waveform generator on counter 1 whose high and low times come from two reload values, a two-input capture unit that timestamps pin edges against counter 1, a pair of independent timers that can each count either prescaled clock ticks or pin edges, or a mixed setup where counter 1 counts pin edges and counter 2 runs as a timer that pin B can capture.

Each counter reloads when it is stepped at zero and raises a sticky underflow flag. Capture events copy the running count into a capture register and raise a sticky capture flag. Software clears flags through a write-one-to-clear input. Both pins are synchronised before edge detection, and the active edge of each pin is programmable.

Top module: `mmtmr_top`

## Requirements
- R1: While rst is high and on the first cycle after it, pwm_out, cap_a, cap_b and all four flags are 0. Both counters and the prescaler start at 0.
- R2: The prescaler issues one tick every pre_div+1 cycles in which en is high (a tick is issued when its count is at or above pre_div, and the count then restarts from 0). While en is low the prescaler holds and neither counter steps.
- R3: A counter stepped at a value above 0 decrements by one. A counter stepped at 0 loads its reload value and sets its sticky underflow flag (uf1_flag, uf2_flag) on the next edge. Counter 2 always reloads from rl2.
- R4: flag_clr bit 0 clears uf1_flag, bit 1 clears uf2_flag, bit 2 clears capa_flag, bit 3 clears capb_flag. A set and a clear in the same cycle leave the flag set.
- R5: The mode encoding is 0 = waveform, 1 = dual capture, 2 = dual timer, 3 = capture plus timer. A mode change takes effect on the next clock edge and does not reset the counters.
- R6: In mode 0, pwm_out toggles at each counter 1 underflow. When it turns high, counter 1 reloads rl1_hi; when it turns low, it reloads rl1_lo. In modes other than 0, pwm_out is 0 and counter 1 reloads rl1_hi.
- R7: Each pin passes through two synchroniser flops. An edge is detected one cycle later, so an edge acts on the third rising clock edge after the pin changes. When the pin's polarity bit is 0 the active edge is rising; when it is 1 it is falling.
- R8: In mode 1, counter 1 steps on ticks. An active edge on pin A copies the counter 1 value into cap_a and sets capa_flag. An active edge on pin B copies it into cap_b and sets capb_flag. The copy is the value held before that clock edge, and captures occur even while en is low.
- R9: In mode 2, src_ext bit 0 makes counter 1 step on pin A edges instead of ticks. Bit 1 does the same for counter 2 with pin B. Edge stepping still requires en high.
- R10: In mode 3, counter 1 steps on pin A edges and counter 2 steps on ticks. An active edge on pin B copies counter 2 into cap_b and sets capb_flag.
- R11: In modes 0 and 2, pin edges leave cap_a, cap_b, capa_flag and capb_flag unchanged. In mode 3, pin A does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for prescaler and counters |
| mode | input | 2 | Operating mode |
| pre_div | input | PRE_W | Prescale divide value minus one |
| src_ext | input | 2 | Per-counter external-edge source select (mode 2) |
| pol_a | input | 1 | Pin A active edge: 0 rising, 1 falling |
| pol_b | input | 1 | Pin B active edge: 0 rising, 1 falling |
| rl1_hi | input | CNT_W | Counter 1 reload (high time in mode 0) |
| rl1_lo | input | CNT_W | Counter 1 low-time reload (mode 0) |
| rl2 | input | CNT_W | Counter 2 reload |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| pin_a | input | 1 | External pin A |
| pin_b | input | 1 | External pin B |
| pwm_out | output | 1 | Waveform output |
| cap_a | output | CNT_W | Capture register A |
| cap_b | output | CNT_W | Capture register B |
| uf1_flag | output | 1 | Counter 1 underflow flag |
| uf2_flag | output | 1 | Counter 2 underflow flag |
| capa_flag | output | 1 | Capture A flag |
| capb_flag | output | 1 | Capture B flag |

## Verification
The bench builds the block with CNT_W = 16 and PRE_W = 4. It uses reload values of only a few counts, so underflows, waveform toggles and reload alternation happen every few cycles. Divide values between 0 and 3 exercise both the undivided path and the restart of a divided tick. Pin stimulus is random and changes every cycle, so edges reach the capture and event paths closely spaced, with both polarities and mode changes in between.

// File: rtl/mmtmr_pkg.sv
package mmtmr_pkg;
  typedef enum logic [1:0] {
    MD_WAVE    = 2'd0,
    MD_DUALCAP = 2'd1,
    MD_DUALTMR = 2'd2,
    MD_CAPTMR  = 2'd3
  } mmtmr_mode_e;

  localparam int NUM_FLAGS = 4;
  localparam int FL_UF1  = 0;
  localparam int FL_UF2  = 1;
  localparam int FL_CAPA = 2;
  localparam int FL_CAPB = 3;
endpackage

// File: rtl/mmtmr_presc.sv
module mmtmr_presc #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = en && (pcnt >= pre_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else if (en) begin
      if (tick) pcnt <= '0;
      else      pcnt <= pcnt + 1'b1;
    end
  end

  AST_PRESC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pcnt)); // R2
endmodule

// File: rtl/mmtmr_edge.sv
module mmtmr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  output logic edge_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[LAST];
    end
  end

  assign edge_hit = pol ? (prev_q & ~sync_q[LAST]) : (~prev_q & sync_q[LAST]);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> (!edge_hit || pol != $past(pol))); // R7
endmodule

// File: rtl/mmtmr_chan.sv
module mmtmr_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             uf
);
  assign uf = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (uf)   cnt <= reload;
    else if (step) cnt <= cnt - 1'b1;
  end

  AST_CHAN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == '0) |=> (cnt == $past(reload))); // R3
  AST_CHAN_DEC: assert property (@(posedge clk) disable iff (rst)
    (step && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R2
endmodule

// File: rtl/mmtmr_top.sv
module mmtmr_top #(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [1:0]       src_ext,
  input  logic             pol_a,
  input  logic             pol_b,
  input  logic [CNT_W-1:0] rl1_hi,
  input  logic [CNT_W-1:0] rl1_lo,
  input  logic [CNT_W-1:0] rl2,
  input  logic [3:0]       flag_clr,
  input  logic             pin_a,
  input  logic             pin_b,
  output logic             pwm_out,
  output logic [CNT_W-1:0] cap_a,
  output logic [CNT_W-1:0] cap_b,
  output logic             uf1_flag,
  output logic             uf2_flag,
  output logic             capa_flag,
  output logic             capb_flag
);
  import mmtmr_pkg::*;

  mmtmr_mode_e md;
  assign md = mmtmr_mode_e'(mode);

  logic tick;
  logic [1:0] pins, pols, edges;
  assign pins = {pin_b, pin_a};
  assign pols = {pol_b, pol_a};

  mmtmr_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst(rst), .en(en), .pre_div(pre_div), .tick(tick)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_pin
    mmtmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .pin(pins[gi]), .pol(pols[gi]), .edge_hit(edges[gi])
    );
  end

  // Step source selection per counter
  logic step1, step2;
  always_comb begin
    unique case (md)
      MD_CAPTMR:  step1 = en && edges[0];
      MD_DUALTMR: step1 = en && (src_ext[0] ? edges[0] : tick);
      default:    step1 = tick;
    endcase
    if (md == MD_DUALTMR && src_ext[1]) step2 = en && edges[1];
    else                                step2 = tick;
  end

  // Counter 1 reload: alternates in waveform mode
  logic [CNT_W-1:0] reload1;
  always_comb begin
    if (md == MD_WAVE && pwm_out) reload1 = rl1_lo;
    else                          reload1 = rl1_hi;
  end

  logic [CNT_W-1:0] cnt1, cnt2;
  logic             uf1, uf2;

  mmtmr_chan #(.CNT_W(CNT_W)) u_chan1 (
    .clk(clk), .rst(rst), .step(step1), .reload(reload1), .cnt(cnt1), .uf(uf1)
  );
  mmtmr_chan #(.CNT_W(CNT_W)) u_chan2 (
    .clk(clk), .rst(rst), .step(step2), .reload(rl2), .cnt(cnt2), .uf(uf2)
  );

  // Capture routing
  logic             cap_a_hit, cap_b_hit;
  logic [CNT_W-1:0] cap_b_src;
  always_comb begin
    cap_a_hit = (md == MD_DUALCAP) && edges[0];
    cap_b_hit = ((md == MD_DUALCAP) || (md == MD_CAPTMR)) && edges[1];
    cap_b_src = (md == MD_CAPTMR) ? cnt2 : cnt1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a <= '0;
      cap_b <= '0;
    end else begin
      if (cap_a_hit) cap_a <= cnt1;
      if (cap_b_hit) cap_b <= cap_b_src;
    end
  end

  // Waveform output
  always_ff @(posedge clk) begin
    if (rst)              pwm_out <= 1'b0;
    else if (md != MD_WAVE) pwm_out <= 1'b0;
    else if (uf1)         pwm_out <= ~pwm_out;
  end

  // Sticky flags, set wins over clear
  logic [NUM_FLAGS-1:0] flag_q, flag_set;
  always_comb begin
    flag_set          = '0;
    flag_set[FL_UF1]  = uf1;
    flag_set[FL_UF2]  = uf2;
    flag_set[FL_CAPA] = cap_a_hit;
    flag_set[FL_CAPB] = cap_b_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign uf1_flag  = flag_q[FL_UF1];
  assign uf2_flag  = flag_q[FL_UF2];
  assign capa_flag = flag_q[FL_CAPA];
  assign capb_flag = flag_q[FL_CAPB];

  AST_WAVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (md != MD_WAVE) |=> !pwm_out); // R6
  AST_UF1_STICKY: assert property (@(posedge clk) disable iff (rst)
    (uf1_flag && !flag_clr[0]) |=> uf1_flag); // R4
  AST_UF_SETS: assert property (@(posedge clk) disable iff (rst)
    uf2 |=> uf2_flag); // R3
  AST_CAPA_QUIET: assert property (@(posedge clk) disable iff (rst)
    (md == MD_WAVE || md == MD_DUALTMR || md == MD_CAPTMR) |=> $stable(cap_a)); // R11
  AST_CAPB_QUIET: assert property (@(posedge clk) disable iff (rst)
    (md == MD_WAVE || md == MD_DUALTMR) |=> $stable(cap_b)); // R11
endmodule

// File: tb/test_mmtmr_top.sv
module test_mmtmr_top;
  localparam int CW = 16;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [PW-1:0] pre_div = '0;
  logic [1:0] src_ext = 2'b00;
  logic pol_a = 1'b0, pol_b = 1'b0;
  logic [CW-1:0] rl1_hi = '0, rl1_lo = '0, rl2 = '0;
  logic [3:0] flag_clr = 4'd0;
  logic pin_a = 1'b0, pin_b = 1'b0;
  logic pwm_out, uf1_flag, uf2_flag, capa_flag, capb_flag;
  logic [CW-1:0] cap_a, cap_b;

  always #4 clk = ~clk;

  mmtmr_top #(.CNT_W(CW), .PRE_W(PW), .SYNC_STAGES(2)) i_mmtmr_top (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .pre_div(pre_div),
    .src_ext(src_ext), .pol_a(pol_a), .pol_b(pol_b), .rl1_hi(rl1_hi),
    .rl1_lo(rl1_lo), .rl2(rl2), .flag_clr(flag_clr), .pin_a(pin_a),
    .pin_b(pin_b), .pwm_out(pwm_out), .cap_a(cap_a), .cap_b(cap_b),
    .uf1_flag(uf1_flag), .uf2_flag(uf2_flag), .capa_flag(capa_flag),
    .capb_flag(capb_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  string phase_req = "R1";

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_pc, m_c1, m_c2, m_capa, m_capb;
  bit m_pwm, m_f0, m_f1, m_f2, m_f3;
  bit pa_h[3], pb_h[3];

  always @(posedge clk) begin
    int pc_n, c1_n, c2_n, capa_n, capb_n, r1;
    bit tk, ea, eb, s1, s2, u1, u2, ca, cb, pwm_n;
    started = 1;
    if (rst) begin
      m_pc = 0; m_c1 = 0; m_c2 = 0; m_capa = 0; m_capb = 0;
      m_pwm = 0; m_f0 = 0; m_f1 = 0; m_f2 = 0; m_f3 = 0;
      for (int i = 0; i < 3; i++) begin pa_h[i] = 0; pb_h[i] = 0; end
    end else begin
      tk = en && (m_pc >= int'(pre_div));
      pc_n = !en ? m_pc : (tk ? 0 : m_pc + 1);
      ea = pol_a ? (pa_h[2] && !pa_h[1]) : (!pa_h[2] && pa_h[1]);
      eb = pol_b ? (pb_h[2] && !pb_h[1]) : (!pb_h[2] && pb_h[1]);
      if (mode == 3) s1 = en && ea;
      else if (mode == 2 && src_ext[0]) s1 = en && ea;
      else s1 = tk;
      s2 = (mode == 2 && src_ext[1]) ? (en && eb) : tk;
      r1 = (mode == 0 && m_pwm) ? int'(rl1_lo) : int'(rl1_hi);
      u1 = s1 && m_c1 == 0;
      u2 = s2 && m_c2 == 0;
      c1_n = !s1 ? m_c1 : (u1 ? r1 : m_c1 - 1);
      c2_n = !s2 ? m_c2 : (u2 ? int'(rl2) : m_c2 - 1);
      pwm_n = (mode != 0) ? 0 : (u1 ? !m_pwm : m_pwm);
      ca = (mode == 1) && ea;
      cb = (mode == 1 || mode == 3) && eb;
      capa_n = ca ? m_c1 : m_capa;
      capb_n = cb ? ((mode == 3) ? m_c2 : m_c1) : m_capb;
      m_f0 = (m_f0 && !flag_clr[0]) || u1;
      m_f1 = (m_f1 && !flag_clr[1]) || u2;
      m_f2 = (m_f2 && !flag_clr[2]) || ca;
      m_f3 = (m_f3 && !flag_clr[3]) || cb;
      m_pc = pc_n; m_c1 = c1_n; m_c2 = c2_n; m_pwm = pwm_n;
      m_capa = capa_n; m_capb = capb_n;
      pa_h[2] = pa_h[1]; pa_h[1] = pa_h[0]; pa_h[0] = pin_a;
      pb_h[2] = pb_h[1]; pb_h[1] = pb_h[0]; pb_h[0] = pin_b;
    end
  end

  function automatic string cap_req();
    if (mode == 1) return "R8";
    if (mode == 3) return "R10";
    return "R11";
  endfunction

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R6", "pwm_out", int'(pwm_out), int'(m_pwm));
      chk(cap_req(), "cap_a", int'(cap_a), m_capa);
      chk(cap_req(), "cap_b", int'(cap_b), m_capb);
      chk(phase_req, "uf1_flag (R3)", int'(uf1_flag), int'(m_f0));
      chk(phase_req, "uf2_flag (R3)", int'(uf2_flag), int'(m_f1));
      chk(cap_req(), "capa_flag", int'(capa_flag), int'(m_f2));
      chk(cap_req(), "capb_flag", int'(capb_flag), int'(m_f3));
    end
  end

  task automatic run(int cycles, bit wiggle);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wiggle) begin
        pin_a = 1'($urandom_range(0, 1));
        pin_b = 1'($urandom_range(0, 1));
      end
      flag_clr = 4'd0;
    end
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int waves;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pwm_out in reset", int'(pwm_out), 0);
    chk("R1", "cap_a in reset", int'(cap_a), 0);
    chk("R1", "flags in reset", int'({uf1_flag, uf2_flag, capa_flag, capb_flag}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "flags after reset", int'({uf1_flag, uf2_flag, capa_flag, capb_flag}), 0);

    // R2 / R3: dual timer on ticks, prescale and enable gating
    phase_req = "R2";
    mode = 2; pre_div = 3; rl1_hi = 5; rl2 = 2; en = 1;
    run(60, 0);
    en = 0; run(20, 1);
    en = 1; pre_div = 0; run(40, 0);

    // R4: clear flags, then clear with simultaneous set
    phase_req = "R4";
    flag_clr = 4'hF; @(negedge clk);
    chk("R4", "flags cleared", int'({uf1_flag, uf2_flag}), 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); flag_clr = 4'h3;
    end
    flag_clr = 4'd0;
    run(10, 0);

    // R6: waveform mode with alternating reloads
    phase_req = "R6";
    mode = 0; rl1_hi = 3; rl1_lo = 6; pre_div = 0;
    waves = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (pwm_out) waves++;
      pin_a = 1'($urandom_range(0, 1));
    end
    chk("R6", "waveform shows high time", int'(waves > 20), 1);
    pre_div = 2; run(80, 1);

    // R8 / R7: dual capture with both polarities
    phase_req = "R7";
    mode = 1; pre_div = 1; rl1_hi = 9;
    run(100, 1);
    pol_a = 1; pol_b = 1; run(100, 1);
    en = 0; run(30, 1); en = 1;
    flag_clr = 4'hC; @(negedge clk); flag_clr = 4'd0;
    run(40, 1);

    // R9: dual timer, each counter on its own pin edges
    phase_req = "R9";
    mode = 2; src_ext = 2'b01; pol_a = 0; rl1_hi = 4; rl2 = 3; run(80, 1);
    src_ext = 2'b10; run(80, 1);
    src_ext = 2'b11; pol_b = 0; run(80, 1);

    // R10: event counter plus captured timer
    phase_req = "R10";
    mode = 3; src_ext = 2'b00; pre_div = 2; run(150, 1);
    pol_b = 1; run(100, 1);

    // R5 / R11: mode hops while pins keep moving
    phase_req = "R5";
    for (int k = 0; k < 12; k++) begin
      mode = 2'(k % 4);
      run(25, 1);
    end
    mode = 2; run(60, 1);
    mode = 0; run(60, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule